// File: doc/BRIEF.md
# Shift and Rotate Execution Unit

This block is the shift and rotate slice of an integer ALU. It takes one operand of either 16 or 32 bits, a shift count, a 3-bit operation code and the current carry flag. It returns the shifted or rotated value together with new carry and overflow flags. Each flag has a write strobe that tells the flag register whether the flag was written by this operation or must keep its old value.

There are eight operations: logical left and right, arithmetic left and right, plain rotate left and right, and rotate left and right through carry. The count is masked to its low five bits before use. Rotates through carry use a ring of width plus one bits. In 16-bit mode the masked count is reduced modulo 17 for these two operations, and modulo 16 for the plain rotates.

The slice has a single pipeline stage. The inputs are captured on a cycle where `in_valid` is high, and the result and flags appear on the following cycle, marked by `out_valid`.

Top module: `shrot_unit`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle where `in_valid` was high outside reset; otherwise it is low.
- R2: Op 0 (logical left) and op 1 (logical right) fill vacated bits with zeros. The carry receives the last bit moved out. A masked count of at least the operand width gives a zero result, and the carry is 0 for any count greater than the width.
- R3: Op 3 (arithmetic right) fills vacated bits with the original top bit, and the carry receives the last bit moved out. Op 2 (arithmetic left) gives the same result and carry as op 0.
- R4: Only `count[4:0]` is used. When those bits are zero, both write strobes are low, the result equals the operand, and `carry_out` echoes `carry_in`.
- R5: Op 4 (rotate left) and op 5 (rotate right) rotate by the masked count modulo the width. When the masked count is non-zero the carry is written. After a left rotate it is the result's bit 0; after a right rotate it is the result's top bit.
- R6: Op 6 (rotate left through carry) and op 7 (rotate right through carry) rotate the concatenation {carry_in, operand} by the masked count modulo (width+1). The new carry is the top bit of the ring. Flags are written only when the reduced count is non-zero.
- R7: The overflow flag is written only when the masked count is 1 and the carry is written. Its value depends on the op:
  - ops 0 and 2: result top bit XOR new carry;
  - op 1: the original top bit;
  - op 3: 0;
  - op 4: result top bit XOR result bit 0;
  - ops 5 and 7: result top bit XOR the bit below it;
  - op 6: result top bit XOR new carry.
  - When not written, `ovf_out` is 0.
- R8: With `size_wide` = 0, the operand's upper 16 bits are ignored and `result[31:16]` is zero. With `size_wide` = 1, all 32 bits are used.
- R9: While `rst` is high, all outputs are 0 on the next clock edge.
- R10: In a cycle without `in_valid`, `result`, `carry_out`, `carry_we`, `ovf_out` and `ovf_we` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inputs carry an operation this cycle |
| op | input | 3 | Operation code (0..7, see R2 to R7) |
| size_wide | input | 1 | 1 selects 32-bit operation, 0 selects 16-bit |
| operand | input | 32 | Value to shift or rotate |
| count | input | 8 | Shift or rotate count, low 5 bits used |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Result and flags are fresh |
| result | output | 32 | Shifted or rotated value |
| carry_out | output | 1 | New carry flag, or carry_in when not written |
| carry_we | output | 1 | Carry flag was written |
| ovf_out | output | 1 | New overflow flag |
| ovf_we | output | 1 | Overflow flag was written |

## Verification
The bench builds the unit with its default widths: a 32-bit wide lane, a 16-bit narrow lane and an 8-bit count input. This puts the mod-17 reduction of the narrow through-carry ring within reach, as well as the 33-bit wide ring where no reduction occurs. It also reaches narrow shift counts between 17 and 31, where the whole operand is shifted out, and the masked-count-zero case, which is reachable through count bit 5.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  typedef enum logic [2:0] {
    OP_SHL = 3'd0,
    OP_SHR = 3'd1,
    OP_SAL = 3'd2,
    OP_SAR = 3'd3,
    OP_ROL = 3'd4,
    OP_ROR = 3'd5,
    OP_RCL = 3'd6,
    OP_RCR = 3'd7
  } shrot_op_e;

  function automatic logic is_plain_rot(shrot_op_e o);
    return (o == OP_ROL) || (o == OP_ROR);
  endfunction

  function automatic logic is_carry_rot(shrot_op_e o);
    return (o == OP_RCL) || (o == OP_RCR);
  endfunction
endpackage

// File: rtl/shrot_flags.sv
module shrot_flags
  import shrot_pkg::*;
(
  input  shrot_op_e op,
  input  logic      cnt_zero,
  input  logic      cnt_one,
  input  logic      ring_zero,
  input  logic      res_top,
  input  logic      res_next,
  input  logic      res_low,
  input  logic      cf_new,
  input  logic      opnd_top,
  output logic      cf_we,
  output logic      of_we,
  output logic      of_val
);
  timeunit 1ns;
  timeprecision 1ps;

  always_comb begin
    if (is_carry_rot(op)) cf_we = !ring_zero;
    else                  cf_we = !cnt_zero;
    of_we = cf_we && cnt_one;
    unique case (op)
      OP_SHL, OP_SAL: of_val = res_top ^ cf_new;
      OP_SHR:         of_val = opnd_top;
      OP_SAR:         of_val = 1'b0;
      OP_ROL:         of_val = res_top ^ res_low;
      OP_ROR, OP_RCR: of_val = res_top ^ res_next;
      OP_RCL:         of_val = res_top ^ cf_new;
      default:        of_val = 1'b0;
    endcase
  end
endmodule

// File: rtl/shrot_lane.sv
module shrot_lane
  import shrot_pkg::*;
#(
  parameter int LW = 16,
  parameter int MW = 5
) (
  input  shrot_op_e       op,
  input  logic [MW-1:0]   cnt_m,
  input  logic [LW-1:0]   opnd,
  input  logic            cin,
  output logic [LW-1:0]   res,
  output logic            cf,
  output logic            cf_we,
  output logic            of_val,
  output logic            of_we
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int RING_W = LW + 1;

  int           m_i;
  int           rot_amt;
  int           ring_amt;
  logic [LW:0]  shl_x;
  logic [LW:0]  shr_x;
  logic [LW:0]  sar_x;
  logic [LW-1:0] rol_v;
  logic [LW-1:0] ror_v;
  logic [LW:0]  ring;
  logic [LW:0]  rcl_x;
  logic [LW:0]  rcr_x;

  always_comb begin
    m_i      = int'(cnt_m);
    rot_amt  = m_i % LW;
    ring_amt = m_i % RING_W;
    // one guard bit catches the last bit moved out
    shl_x    = {1'b0, opnd} << m_i;
    shr_x    = {opnd, 1'b0} >> m_i;
    sar_x    = $signed({opnd, 1'b0}) >>> m_i;
    rol_v    = (opnd << rot_amt) | (opnd >> (LW - rot_amt));
    ror_v    = (opnd >> rot_amt) | (opnd << (LW - rot_amt));
    ring     = {cin, opnd};
    rcl_x    = (ring << ring_amt) | (ring >> (RING_W - ring_amt));
    rcr_x    = (ring >> ring_amt) | (ring << (RING_W - ring_amt));
  end

  always_comb begin
    unique case (op)
      OP_SHL, OP_SAL: begin res = shl_x[LW-1:0]; cf = shl_x[LW]; end
      OP_SHR:         begin res = shr_x[LW:1];   cf = shr_x[0];  end
      OP_SAR:         begin res = sar_x[LW:1];   cf = sar_x[0];  end
      OP_ROL:         begin res = rol_v;         cf = rol_v[0];  end
      OP_ROR:         begin res = ror_v;         cf = ror_v[LW-1]; end
      OP_RCL:         begin res = rcl_x[LW-1:0]; cf = rcl_x[LW]; end
      OP_RCR:         begin res = rcr_x[LW-1:0]; cf = rcr_x[LW]; end
      default:        begin res = opnd;          cf = cin;       end
    endcase
  end

  shrot_flags u_flags (
    .op        (op),
    .cnt_zero  (m_i == 0),
    .cnt_one   (m_i == 1),
    .ring_zero (ring_amt == 0),
    .res_top   (res[LW-1]),
    .res_next  (res[LW-2]),
    .res_low   (res[0]),
    .cf_new    (cf),
    .opnd_top  (opnd[LW-1]),
    .cf_we     (cf_we),
    .of_we     (of_we),
    .of_val    (of_val)
  );
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int WIDE_W   = 32,
  parameter int NARROW_W = 16,
  parameter int CNT_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        op,
  input  logic              size_wide,
  input  logic [WIDE_W-1:0] operand,
  input  logic [CNT_W-1:0]  count,
  input  logic              carry_in,
  output logic              out_valid,
  output logic [WIDE_W-1:0] result,
  output logic              carry_out,
  output logic              carry_we,
  output logic              ovf_out,
  output logic              ovf_we
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int MW    = $clog2(WIDE_W);
  localparam int LANES = 2;

  shrot_op_e         op_e;
  logic [MW-1:0]     cnt_m;
  logic              unused_cnt_hi;
  logic [WIDE_W-1:0] lane_res [LANES];
  logic              lane_cf  [LANES];
  logic              lane_cfw [LANES];
  logic              lane_of  [LANES];
  logic              lane_ofw [LANES];
  logic [WIDE_W-1:0] sel_res;
  logic              sel_cf, sel_cfw, sel_of, sel_ofw;
  logic [WIDE_W-1:0] sized_opnd;

  assign op_e          = shrot_op_e'(op);
  assign cnt_m         = count[MW-1:0];
  assign unused_cnt_hi = ^count[CNT_W-1:MW];

  // lane 0 is narrow, lane 1 is wide
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int LW = (g == 0) ? NARROW_W : WIDE_W;
    logic [LW-1:0] res_g;
    shrot_lane #(.LW(LW), .MW(MW)) u_lane (
      .op     (op_e),
      .cnt_m  (cnt_m),
      .opnd   (operand[LW-1:0]),
      .cin    (carry_in),
      .res    (res_g),
      .cf     (lane_cf[g]),
      .cf_we  (lane_cfw[g]),
      .of_val (lane_of[g]),
      .of_we  (lane_ofw[g])
    );
    assign lane_res[g] = WIDE_W'(res_g);
  end

  always_comb begin
    sel_res    = lane_res[size_wide];
    sel_cf     = lane_cf[size_wide];
    sel_cfw    = lane_cfw[size_wide];
    sel_of     = lane_of[size_wide];
    sel_ofw    = lane_ofw[size_wide];
    sized_opnd = size_wide ? operand : WIDE_W'(operand[NARROW_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      carry_out <= 1'b0;
      carry_we  <= 1'b0;
      ovf_out   <= 1'b0;
      ovf_we    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= sel_res;
        carry_out <= sel_cfw ? sel_cf : carry_in;
        carry_we  <= sel_cfw;
        ovf_out   <= sel_ofw & sel_of;
        ovf_we    <= sel_ofw;
      end
    end
  end

  // R1
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r1_idle_no_valid: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R4
  a_r4_zero_count_no_write: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cnt_m == '0) |=> (!carry_we && !ovf_we));
  a_r4_unwritten_carry_echo: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !sel_cfw) |=> (carry_out == $past(carry_in)));
  // R7
  a_r7_ovf_needs_carry: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (!ovf_we || carry_we));
  // R5
  a_r5_rotate_keeps_ones: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_plain_rot(op_e)) |-> ($countones(sel_res) == $countones(sized_opnd)));
  // R6
  a_r6_ring_keeps_ones: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_carry_rot(op_e)) |->
      ($countones({sel_cf, sel_res}) == $countones({carry_in, sized_opnd})));
  // R8
  a_r8_narrow_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !size_wide) |=> (result[WIDE_W-1:NARROW_W] == '0));
endmodule

// File: tb/sim_shrot_unit.sv
module sim_shrot_unit;
  timeunit 1ns;
  timeprecision 1ps;

  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  op;
    logic        wide;
    logic [31:0] a;
    logic [7:0]  cnt;
    logic        cin;
    logic [31:0] res;
    logic        cf;
    logic        cfw;
    logic        of;
    logic        ofw;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{4'd2, 3'd1, 1'b0, 32'h0000FF00, 8'd3,  1'b0, 32'h00001FE0, 1'b0, 1'b1, 1'b0, 1'b0}, // R2
    '{4'd3, 3'd2, 1'b0, 32'h0000FF00, 8'd2,  1'b0, 32'h0000FC00, 1'b1, 1'b1, 1'b0, 1'b0}, // R3
    '{4'd3, 3'd3, 1'b0, 32'h0000FC00, 8'd5,  1'b0, 32'h0000FFE0, 1'b0, 1'b1, 1'b0, 1'b0}, // R3
    '{4'd7, 3'd0, 1'b0, 32'h00008001, 8'd1,  1'b0, 32'h00000002, 1'b1, 1'b1, 1'b1, 1'b1}, // R7
    '{4'd7, 3'd1, 1'b1, 32'h80000001, 8'd1,  1'b0, 32'h40000000, 1'b1, 1'b1, 1'b1, 1'b1}, // R7
    '{4'd7, 3'd3, 1'b1, 32'h80000000, 8'd1,  1'b0, 32'hC0000000, 1'b0, 1'b1, 1'b0, 1'b1}, // R7
    '{4'd4, 3'd1, 1'b0, 32'h00001234, 8'd32, 1'b1, 32'h00001234, 1'b1, 1'b0, 1'b0, 1'b0}, // R4
    '{4'd2, 3'd0, 1'b0, 32'h00000001, 8'd16, 1'b0, 32'h00000000, 1'b1, 1'b1, 1'b0, 1'b0}, // R2
    '{4'd2, 3'd1, 1'b0, 32'h0000FFFF, 8'd20, 1'b1, 32'h00000000, 1'b0, 1'b1, 1'b0, 1'b0}, // R2
    '{4'd3, 3'd3, 1'b0, 32'h00008000, 8'd31, 1'b0, 32'h0000FFFF, 1'b1, 1'b1, 1'b0, 1'b0}, // R3
    '{4'd7, 3'd4, 1'b0, 32'h00008001, 8'd1,  1'b0, 32'h00000003, 1'b1, 1'b1, 1'b1, 1'b1}, // R7
    '{4'd7, 3'd5, 1'b0, 32'h00000007, 8'd1,  1'b0, 32'h00008003, 1'b1, 1'b1, 1'b1, 1'b1}, // R7
    '{4'd5, 3'd5, 1'b1, 32'h12345678, 8'd8,  1'b1, 32'h78123456, 1'b0, 1'b1, 1'b0, 1'b0}, // R5
    '{4'd5, 3'd4, 1'b1, 32'h12345678, 8'h24, 1'b0, 32'h23456781, 1'b1, 1'b1, 1'b0, 1'b0}, // R5
    '{4'd5, 3'd4, 1'b0, 32'h00001234, 8'd16, 1'b1, 32'h00001234, 1'b0, 1'b1, 1'b0, 1'b0}, // R5
    '{4'd6, 3'd6, 1'b0, 32'h00008000, 8'd1,  1'b0, 32'h00000000, 1'b1, 1'b1, 1'b1, 1'b1}, // R6
    '{4'd6, 3'd7, 1'b0, 32'h00000001, 8'd1,  1'b1, 32'h00008000, 1'b1, 1'b1, 1'b1, 1'b1}, // R6
    '{4'd6, 3'd6, 1'b0, 32'h00001234, 8'd17, 1'b1, 32'h00001234, 1'b1, 1'b0, 1'b0, 1'b0}, // R6
    '{4'd6, 3'd6, 1'b0, 32'h00000001, 8'd18, 1'b0, 32'h00000002, 1'b0, 1'b1, 1'b0, 1'b0}, // R6
    '{4'd6, 3'd7, 1'b1, 32'h00000001, 8'd2,  1'b0, 32'h80000000, 1'b0, 1'b1, 1'b0, 1'b0}, // R6
    '{4'd6, 3'd6, 1'b1, 32'h80000000, 8'd1,  1'b1, 32'h00000001, 1'b1, 1'b1, 1'b1, 1'b1}, // R6
    '{4'd5, 3'd5, 1'b1, 32'h00000001, 8'd31, 1'b0, 32'h00000002, 1'b0, 1'b1, 1'b0, 1'b0}, // R5
    '{4'd2, 3'd0, 1'b1, 32'h00000003, 8'd31, 1'b0, 32'h80000000, 1'b1, 1'b1, 1'b0, 1'b0}, // R2
    '{4'd8, 3'd1, 1'b0, 32'hABCD8000, 8'd4,  1'b0, 32'h00000800, 1'b0, 1'b1, 1'b0, 1'b0}  // R8
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic        size_wide = 1'b0;
  logic [31:0] operand = '0;
  logic [7:0]  count = '0;
  logic        carry_in = 1'b0;
  logic        out_valid;
  logic [31:0] result;
  logic        carry_out, carry_we, ovf_out, ovf_we;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  shrot_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .size_wide(size_wide),
    .operand(operand), .count(count), .carry_in(carry_in), .out_valid(out_valid),
    .result(result), .carry_out(carry_out), .carry_we(carry_we),
    .ovf_out(ovf_out), .ovf_we(ovf_we)
  );

  task automatic check(input string tag, input logic [36:0] act, input logic [36:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input logic valid);
    in_valid  = valid;
    op        = v.op;
    size_wide = v.wide;
    operand   = v.a;
    count     = v.cnt;
    carry_in  = v.cin;
  endtask

  function automatic logic [36:0] outs();
    return {out_valid, result, carry_out, carry_we, ovf_out, ovf_we};
  endfunction

  initial begin
    // R9: reset with a live request on the inputs
    @(negedge clk);
    drive(VECS[0], 1'b1);
    @(negedge clk);
    @(negedge clk);
    check("R9 reset", outs(), 37'd0);
    in_valid = 1'b0;
    rst = 1'b0;

    // table walk, one request per cycle, each result seen one cycle later (R1)
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i], 1'b1);
      @(negedge clk);
      in_valid = 1'b0;
      check($sformatf("R%0d vec %0d", VECS[i].req, i), outs(),
            {1'b1, VECS[i].res, VECS[i].cf, VECS[i].cfw, VECS[i].of, VECS[i].ofw});
    end

    // R1 and R10: an idle cycle drops out_valid and holds the rest
    drive(VECS[4], 1'b0);
    @(negedge clk);
    check("R10 hold idle", outs(),
          {1'b0, VECS[NV-1].res, VECS[NV-1].cf, VECS[NV-1].cfw, VECS[NV-1].of, VECS[NV-1].ofw});

    // R1: nothing appears before the capturing edge
    drive(VECS[3], 1'b1);
    #1;
    check("R1 no early valid", {36'd0, out_valid}, 37'd0);
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 one cycle later", outs(), {1'b1, 32'h00000002, 1'b1, 1'b1, 1'b1, 1'b1});
    @(negedge clk);
    check("R1 single pulse", {36'd0, out_valid}, 37'd0);

    // R4: count bits above bit 4 are ignored (0x41 acts as 1, rotate left wide)
    drive('{4'd4, 3'd4, 1'b1, 32'h80000000, 8'h41, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0, 1'b0}, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R4 upper count bits", outs(), {1'b1, 32'h00000001, 1'b1, 1'b1, 1'b1, 1'b1});

    // R4: zero masked count on a through-carry rotate, carry echoed low
    drive('{4'd4, 3'd7, 1'b1, 32'hDEADBEEF, 8'hE0, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0, 1'b0}, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R4 zero count rcr", outs(), {1'b1, 32'hDEADBEEF, 1'b0, 1'b0, 1'b0, 1'b0});

    // R9: reset mid-stream clears everything again
    drive(VECS[12], 1'b1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b0;
    check("R9 reset again", outs(), 37'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule